// File: doc/BRIEF.md
# Motion Sample FIFO with Per-Source Decimation and Watermark

This block buffers 16-bit samples coming from two independent motion sensors, a gyroscope and an accelerometer, each delivering a three-axis sample vector. Every source has its own 3-bit decimation code. The code either keeps the source out of the FIFO or stores one sample out of every N triggers. A mode bit picks what counts as a trigger. It is either each source's own data-ready strobe or a shared step-event strobe that both sources count.

The status side reports the unread-word level, a watermark flag against a programmable 12-bit threshold, full, empty and a sticky overrun flag. An optional stop-at-watermark mode caps the stored level at the threshold. Words are read one per request through a registered read port. A synchronous clear empties the storage and restarts both decimation counters.

Top module: `motion_sample_fifo`

## Requirements
- R1: A source with decimation code 000 never writes. Codes 001, 010, 011, 100, 101, 110 and 111 give factors 1, 2, 3, 4, 8, 16 and 32. The source writes on the 1st, (1+f)th, (1+2f)th ... trigger after reset or clear.
- R2: A writing source stores three words, X then Y then Z, taken from its data port as X=[15:0], Y=[31:16] and Z=[47:32]. When both sources write in the same cycle, the gyroscope words come first.
- R3: With trigOnStep=0 each source counts only its own ready strobe and stepPulse has no effect. With trigOnStep=1 both sources count stepPulse and the ready strobes have no effect.
- R4: level equals the words accepted minus the words popped. It updates on the clock edge that samples the trigger or the pop.
- R5: markHit is 1 exactly when level >= markLevel.
- R6: isEmpty is 1 exactly when level is 0, and isFull is 1 exactly when level equals DEPTH (default 1024).
- R7: Words that do not fit below the limit are dropped from the tail of the frame. The stored order is kept and overrun becomes 1.
- R8: With stopAtMark=1 the limit is min(markLevel, DEPTH) instead of DEPTH.
- R9: overrun stays 1 until a pop is accepted or clear is applied. A drop in the same cycle as an accepted pop leaves it at 1.
- R10: popReq while level>0 presents the oldest word on popData one cycle later and removes it.
- R11: popReq while level is 0 drives popData to 0 one cycle later and does not advance the read position.
- R12: clear empties the FIFO, zeroes popData and overrun, and restarts both decimation counters. It takes priority over writes and pops in the same cycle.
- R13: After reset level is 0, isEmpty is 1, isFull, markHit (markLevel>0) and overrun are 0, and popData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous flush of storage, counters and flags |
| gyroCode | input | 3 | Gyroscope decimation code |
| accelCode | input | 3 | Accelerometer decimation code |
| trigOnStep | input | 1 | 0: ready strobes trigger, 1: step strobe triggers |
| stopAtMark | input | 1 | Cap the level at markLevel |
| markLevel | input | 12 | Watermark threshold |
| gyroReady | input | 1 | Gyroscope data-ready strobe |
| accelReady | input | 1 | Accelerometer data-ready strobe |
| stepPulse | input | 1 | Step event strobe |
| gyroData | input | 48 | Gyroscope sample {Z,Y,X} |
| accelData | input | 48 | Accelerometer sample {Z,Y,X} |
| popReq | input | 1 | Read one word |
| popData | output | 16 | Word read, valid the cycle after popReq |
| level | output | 12 | Unread word count |
| markHit | output | 1 | level >= markLevel |
| isFull | output | 1 | level equals DEPTH |
| isEmpty | output | 1 | level is 0 |
| overrun | output | 1 | Sticky drop flag |

## Verification
The bound checker enforces several properties on every cycle. It checks that full and empty never coincide, that the level never exceeds the depth or moves by more than six up or one down, that an empty pop yields zero, and that overrun stays set until a pop or clear. It also checks that a cleared FIFO is empty on the next cycle and that with stop-at-watermark the level cannot grow once the threshold is met. Only the directed scenarios can show the decimation pattern of each code, the word order within and across frames, and the trigger-mode selection. The same holds for tail dropping at the depth and at the threshold, and for a clear restarting a decimation count midway.

// File: rtl/smf_pkg.sv
package smf_pkg;

  // Strobes from control to storage for one cycle
  typedef struct packed {
    logic       gyroLead;  // gyroscope words occupy the first frame slots
    logic [2:0] wrCount;   // number of frame words to store this cycle
    logic       popOk;     // remove the oldest word
    logic       popNil;    // read request with nothing to give
    logic       flush;     // synchronous clear
  } smf_strobe_t;

  // Decimation factor for a 3-bit code; code 0 (excluded) returns 1
  function automatic logic [5:0] dec_factor(input logic [2:0] code);
    logic [5:0] f;
    unique case (code)
      3'd2:    f = 6'd2;
      3'd3:    f = 6'd3;
      3'd4:    f = 6'd4;
      3'd5:    f = 6'd8;
      3'd6:    f = 6'd16;
      3'd7:    f = 6'd32;
      default: f = 6'd1;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/smf_decim.sv
module smf_decim (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic [2:0] code,
  input  logic       tick,
  output logic       fire
);
  logic [5:0] factor;
  logic [4:0] phase;
  logic       enabled;

  assign factor  = smf_pkg::dec_factor(code);
  assign enabled = (code != 3'b000);
  assign fire    = tick && enabled && (phase == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (clear) begin
      phase <= '0;
    end else if (tick && enabled) begin
      if (({1'b0, phase} + 6'd1) >= factor) phase <= '0;
      else                                  phase <= phase + 5'd1;
    end
  end
endmodule

// File: rtl/smf_ctrl.sv
module smf_ctrl #(
  parameter int DEPTH = 1024,
  parameter int LVL_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  logic [2:0]              gyroCode,
  input  logic [2:0]              accelCode,
  input  logic                    trigOnStep,
  input  logic                    stopAtMark,
  input  logic [LVL_W-1:0]        markLevel,
  input  logic                    gyroReady,
  input  logic                    accelReady,
  input  logic                    stepPulse,
  input  logic                    popReq,
  output smf_pkg::smf_strobe_t    strobe,
  output logic [LVL_W-1:0]        level,
  output logic                    markHit,
  output logic                    isFull,
  output logic                    isEmpty,
  output logic                    overrun
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int WW    = ((CNT_W > LVL_W) ? CNT_W : LVL_W) + 1;
  localparam int NSRC  = 2;  // index 0 gyroscope, 1 accelerometer

  logic [CNT_W-1:0] count;
  logic [2:0]       codes [NSRC];
  logic [NSRC-1:0]  ticks;
  logic [NSRC-1:0]  fires;

  assign codes[0] = gyroCode;
  assign codes[1] = accelCode;
  assign ticks[0] = trigOnStep ? stepPulse : gyroReady;
  assign ticks[1] = trigOnStep ? stepPulse : accelReady;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    smf_decim u_dec (
      .clk   (clk),
      .rstN  (rstN),
      .clear (clear),
      .code  (codes[s]),
      .tick  (ticks[s]),
      .fire  (fires[s])
    );
  end

  logic [2:0]    wanted;
  logic [2:0]    accept;
  logic [WW-1:0] cntW, markW, limit, room;
  logic          dropped;
  logic          popOk;

  always_comb begin
    wanted = 3'd0;
    if (!clear) begin
      if (fires[0]) wanted = wanted + 3'd3;
      if (fires[1]) wanted = wanted + 3'd3;
    end
    cntW  = WW'(count);
    markW = WW'(markLevel);
    limit = WW'(DEPTH);
    if (stopAtMark && (markW < limit)) limit = markW;
    room  = (limit > cntW) ? (limit - cntW) : '0;
    accept = (WW'(wanted) > room) ? room[2:0] : wanted;
    dropped = (accept != wanted);
  end

  assign popOk = popReq && (count != '0) && !clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      overrun <= 1'b0;
    end else if (clear) begin
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      count <= count + CNT_W'(accept) - CNT_W'(popOk);
      if (dropped)    overrun <= 1'b1;
      else if (popOk) overrun <= 1'b0;
    end
  end

  assign strobe.gyroLead = fires[0];
  assign strobe.wrCount  = accept;
  assign strobe.popOk    = popOk;
  assign strobe.popNil   = popReq && ((count == '0) || clear);
  assign strobe.flush    = clear;

  assign level   = LVL_W'(count);
  assign markHit = (cntW >= markW);
  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);
endmodule

// File: rtl/smf_store.sv
module smf_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  smf_pkg::smf_strobe_t    strobe,
  input  logic [3*WORD_W-1:0]     gyroData,
  input  logic [3*WORD_W-1:0]     accelData,
  output logic [WORD_W-1:0]       popData
);
  localparam int AW    = $clog2(DEPTH);
  localparam int SLOTS = 6;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [WORD_W-1:0] frame [SLOTS];

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      frame[k]     = strobe.gyroLead ? gyroData[k*WORD_W +: WORD_W]
                                     : accelData[k*WORD_W +: WORD_W];
      frame[k + 3] = accelData[k*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < SLOTS; k++) begin
      if (k < int'(strobe.wrCount)) mem[wrPtr + AW'(k)] <= frame[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      popData <= '0;
    end else if (strobe.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      popData <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(strobe.wrCount);
      if (strobe.popOk) begin
        popData <= mem[rdPtr];
        rdPtr   <= rdPtr + AW'(1);
      end else if (strobe.popNil) begin
        popData <= '0;
      end
    end
  end
endmodule

// File: rtl/motion_sample_fifo.sv
module motion_sample_fifo #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 1024,
  parameter int LVL_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clear,
  input  logic [2:0]          gyroCode,
  input  logic [2:0]          accelCode,
  input  logic                trigOnStep,
  input  logic                stopAtMark,
  input  logic [LVL_W-1:0]    markLevel,
  input  logic                gyroReady,
  input  logic                accelReady,
  input  logic                stepPulse,
  input  logic [3*WORD_W-1:0] gyroData,
  input  logic [3*WORD_W-1:0] accelData,
  input  logic                popReq,
  output logic [WORD_W-1:0]   popData,
  output logic [LVL_W-1:0]    level,
  output logic                markHit,
  output logic                isFull,
  output logic                isEmpty,
  output logic                overrun
);
  smf_pkg::smf_strobe_t strobe;

  smf_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clear      (clear),
    .gyroCode   (gyroCode),
    .accelCode  (accelCode),
    .trigOnStep (trigOnStep),
    .stopAtMark (stopAtMark),
    .markLevel  (markLevel),
    .gyroReady  (gyroReady),
    .accelReady (accelReady),
    .stepPulse  (stepPulse),
    .popReq     (popReq),
    .strobe     (strobe),
    .level      (level),
    .markHit    (markHit),
    .isFull     (isFull),
    .isEmpty    (isEmpty),
    .overrun    (overrun)
  );

  smf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .gyroData  (gyroData),
    .accelData (accelData),
    .popData   (popData)
  );
endmodule

// File: rtl/smf_checker.sv
module smf_checker #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 1024,
  parameter int LVL_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              clear,
  input logic              stopAtMark,
  input logic [LVL_W-1:0]  markLevel,
  input logic              popReq,
  input logic [WORD_W-1:0] popData,
  input logic [LVL_W-1:0]  level,
  input logic              isFull,
  input logic              isEmpty,
  input logic              overrun
);
  // R6: full and empty are exclusive
  p_full_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(isFull && isEmpty));

  // R7: level never passes the depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    int'(level) <= DEPTH);

  // R4: at most two frames in, at most one word out per cycle
  p_level_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> (int'(level) <= int'($past(level)) + 6) &&
               (int'(level) >= int'($past(level)) - 1));

  // R11: empty pop gives zero
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && isEmpty) |=> (popData == '0));

  // R9: overrun is sticky without pop or clear
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !popReq && !clear) |=> overrun);

  // R12: clear leaves an empty FIFO with no overrun
  p_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (isEmpty && !overrun && (popData == '0)));

  // R8: at the threshold in stop mode the level cannot rise
  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopAtMark && (level >= markLevel) && !clear) |=> (level <= $past(level)));
endmodule

bind motion_sample_fifo smf_checker #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clear      (clear),
  .stopAtMark (stopAtMark),
  .markLevel  (markLevel),
  .popReq     (popReq),
  .popData    (popData),
  .level      (level),
  .isFull     (isFull),
  .isEmpty    (isEmpty),
  .overrun    (overrun)
);

// File: tb/tb_motion_sample_fifo.sv
`timescale 1ns/1ps
module tb_motion_sample_fifo;
  localparam int W     = 16;
  localparam int DEPTH = 1024;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clear = 1'b0;
  logic [2:0]    gyroCode = 3'd0, accelCode = 3'd0;
  logic          trigOnStep = 1'b0, stopAtMark = 1'b0;
  logic [11:0]   markLevel = 12'd100;
  logic          gyroReady = 1'b0, accelReady = 1'b0, stepPulse = 1'b0;
  logic [3*W-1:0] gyroData = '0, accelData = '0;
  logic          popReq = 1'b0;
  logic [W-1:0]  popData;
  logic [11:0]   level;
  logic          markHit, isFull, isEmpty, overrun;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  motion_sample_fifo dut (
    .clk(clk), .rstN(rstN), .clear(clear), .gyroCode(gyroCode), .accelCode(accelCode),
    .trigOnStep(trigOnStep), .stopAtMark(stopAtMark), .markLevel(markLevel),
    .gyroReady(gyroReady), .accelReady(accelReady), .stepPulse(stepPulse),
    .gyroData(gyroData), .accelData(accelData), .popReq(popReq), .popData(popData),
    .level(level), .markHit(markHit), .isFull(isFull), .isEmpty(isEmpty), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic pulse(input logic g, input logic a, input logic s);
    gyroReady = g; accelReady = a; stepPulse = s;
    @(negedge clk);
    gyroReady = 1'b0; accelReady = 1'b0; stepPulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic popOne(output int v);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    v = int'(popData);
  endtask

  task automatic doClear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic setup(input logic [2:0] gc, input logic [2:0] ac, input logic step,
                       input logic stop, input int mark);
    gyroCode = gc; accelCode = ac; trigOnStep = step; stopAtMark = stop;
    markLevel = 12'(mark);
    doClear();
  endtask

  task automatic t_reset();
    chk("R13 level", int'(level), 0);
    chk("R13 isEmpty", int'(isEmpty), 1);
    chk("R13 isFull", int'(isFull), 0);
    chk("R13 overrun", int'(overrun), 0);
    chk("R13 markHit", int'(markHit), 0);
    chk("R13 popData", int'(popData), 0);
  endtask

  task automatic t_order();
    int v;
    setup(3'd1, 3'd1, 1'b0, 1'b0, 100);
    gyroData  = {16'h1003, 16'h1002, 16'h1001};
    accelData = {16'h2003, 16'h2002, 16'h2001};
    pulse(1'b1, 1'b1, 1'b0);
    chk("R4 level after two-source frame", int'(level), 6);
    popOne(v); chk("R2 gyro X first", v, 'h1001);
    popOne(v); chk("R2 gyro Y", v, 'h1002);
    popOne(v); chk("R2 gyro Z", v, 'h1003);
    popOne(v); chk("R2 accel X after gyro", v, 'h2001);
    popOne(v); chk("R10 accel Y", v, 'h2002);
    popOne(v); chk("R10 accel Z", v, 'h2003);
    chk("R6 empty after draining", int'(isEmpty), 1);
    // accelerometer alone
    pulse(1'b0, 1'b1, 1'b0);
    popOne(v); chk("R2 accel-only frame starts with X", v, 'h2001);
  endtask

  task automatic t_decim();
    int fac [8] = '{1, 1, 2, 3, 4, 8, 16, 32};
    for (int c = 0; c < 8; c++) begin
      setup(3'd0, 3'(c), 1'b0, 1'b0, 100);
      for (int p = 0; p < fac[c] + 1; p++) pulse(1'b0, 1'b1, 1'b0);
      chk($sformatf("R1 code %0d two frames", c), int'(level), (c == 0) ? 0 : 6);
    end
    setup(3'd3, 3'd0, 1'b0, 1'b0, 100);
    for (int p = 0; p < 7; p++) pulse(1'b1, 1'b0, 1'b0);
    chk("R1 factor 3 over 7 triggers", int'(level), 9);
  endtask

  task automatic t_trigger();
    setup(3'd1, 3'd1, 1'b1, 1'b0, 100);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R3 ready ignored in step mode", int'(level), 0);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R3 step triggers both sources", int'(level), 6);
    setup(3'd1, 3'd1, 1'b0, 1'b0, 100);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R3 step ignored in ready mode", int'(level), 0);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R3 gyro ready alone", int'(level), 3);
  endtask

  task automatic t_mark();
    int v;
    setup(3'd1, 3'd0, 1'b0, 1'b0, 6);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R5 below mark", int'(markHit), 0);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R5 equal to mark", int'(markHit), 1);
    popOne(v);
    chk("R5 one below mark after pop", int'(markHit), 0);
    chk("R4 level after pop", int'(level), 5);
  endtask

  task automatic t_stop();
    int v;
    setup(3'd1, 3'd1, 1'b0, 1'b1, 4);
    gyroData  = {16'h1003, 16'h1002, 16'h1001};
    accelData = {16'h2003, 16'h2002, 16'h2001};
    pulse(1'b1, 1'b1, 1'b0);
    chk("R8 capped at mark", int'(level), 4);
    chk("R8 tail dropped sets overrun", int'(overrun), 1);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R8 no growth at mark", int'(level), 4);
    chk("R9 overrun held", int'(overrun), 1);
    popOne(v); chk("R7 order kept after drop", v, 'h1001);
    chk("R9 overrun cleared by pop", int'(overrun), 0);
    popOne(v); popOne(v); popOne(v);
    chk("R7 last kept word", v, 'h2001);
  endtask

  task automatic t_fill();
    int v;
    bit seqOk = 1'b1;
    int firstBad = -1;
    setup(3'd1, 3'd0, 1'b0, 1'b0, 4095);
    for (int f = 0; f < 342; f++) begin
      gyroData = {16'(3*f + 2), 16'(3*f + 1), 16'(3*f)};
      pulse(1'b1, 1'b0, 1'b0);
    end
    chk("R6 level at depth", int'(level), DEPTH);
    chk("R6 isFull", int'(isFull), 1);
    chk("R7 overrun at full", int'(overrun), 1);
    for (int i = 0; i < DEPTH; i++) begin
      popOne(v);
      if (seqOk && v != i) begin seqOk = 1'b0; firstBad = i; end
    end
    chk("R10 FIFO order over full depth (first bad index)", firstBad, -1);
    chk("R6 empty after full drain", int'(isEmpty), 1);
    pulse(1'b1, 1'b0, 1'b0);
    doClear();
    chk("R12 clear empties", int'(level), 0);
    chk("R12 clear zeroes popData", int'(popData), 0);
  endtask

  task automatic t_empty_pop();
    int v;
    setup(3'd1, 3'd0, 1'b0, 1'b0, 100);
    gyroData = {16'h3003, 16'h3002, 16'h3001};
    pulse(1'b1, 1'b0, 1'b0);
    popOne(v); popOne(v); popOne(v);
    chk("R10 last word nonzero", v, 'h3003);
    popOne(v);
    chk("R11 empty pop returns 0", v, 0);
    chk("R11 level stays 0", int'(level), 0);
    gyroData = {16'h4003, 16'h4002, 16'h4001};
    pulse(1'b1, 1'b0, 1'b0);
    popOne(v);
    chk("R11 read position not moved", v, 'h4001);
  endtask

  task automatic t_clear_counter();
    setup(3'd0, 3'd3, 1'b0, 1'b0, 100);
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R1 factor 3 after two triggers", int'(level), 3);
    doClear();
    pulse(1'b0, 1'b1, 1'b0);
    chk("R12 clear restarts decimation", int'(level), 3);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_decim();
    t_trigger();
    t_mark();
    t_stop();
    t_fill();
    t_empty_pop();
    t_clear_counter();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule